// File: doc/BRIEF.md
# Preset Up/Down Event Counter

This block counts events for a scan-based controller. Each clock cycle is one scan. When the count input goes from low to high, the accumulated value moves by one step. A direction bit selects whether that step is up or down. A clear bit returns the value to zero. The status output is high whenever the accumulated value has reached the preset.

A three-bit type code sets two properties of the counter. The first is whether counting up may pass the preset. The second is whether the value survives a power loss. Power loss is modelled at the ports. The accumulated value can be stored externally at any time. After a restart, a one-cycle restore strobe reloads the stored value for retentive types and loads zero for the others.

The value is always held between 0 and `MAX_VAL`. The default `MAX_VAL` is 999999.

Top module: `preset_event_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc` is 0. With a nonzero preset, `hit` is 0 in that state.
- R2: Each low-to-high change of `count_in` moves `acc` by exactly one step. The new value appears on the clock edge that samples `count_in` high. Holding `count_in` high produces no further steps.
- R3: When `dir_dn` is 1 at the sampled edge, the step is downward. When `dir_dn` is 0, the step is upward.
- R4: When `clr` is high, `acc` is 0 after the next clock edge. This takes priority over a count edge and over a restore in the same cycle.
- R5: `hit` is 1 exactly when `acc` is greater than or equal to `preset`. This includes a preset of 0.
- R6: For type codes 1 and 3, and for the unused codes 0 and 7, an upward step is taken only while `acc` is below `preset`. Downward steps are still allowed.
- R7: For type codes 2, 4, 5 and 6, upward steps may pass the preset. `acc` never rises above 999999.
- R8: A downward step when `acc` is 0 leaves `acc` at 0.
- R9: A one-cycle `restore` strobe sets `acc` on the next edge. For type codes 3, 4 and 6 it loads `saved_val`, limited to 999999. For every other code it loads 0. The strobe takes priority over a count edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, one scan per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_in | input | 1 | Rung condition being counted |
| dir_dn | input | 1 | 1 selects downward counting |
| clr | input | 1 | Clear accumulated value |
| ctype | input | 3 | Counter type code |
| preset | input | 20 | Comparison threshold |
| restore | input | 1 | Power-up reload strobe |
| saved_val | input | 20 | Value kept across power loss |
| acc | output | 20 | Accumulated value |
| hit | output | 1 | Status: acc >= preset |

## Verification
The clear and the count edge can land in the same scan. The restore strobe and the count edge can also land in the same scan. The bench provokes each pairing by raising `count_in` in the very cycle that `clr` or `restore` is high. It then expects the clear or the reload to win, with no extra step added. Every type code is swept through counting past the preset, counting down through zero and restoring, and each value is compared with a count kept arithmetically in the bench.

// File: rtl/scan_cnt_pkg.sv
package scan_cnt_pkg;

   typedef struct packed {
      logic pass_preset;
      logic keep_on_loss;
   } ctype_attr_t;

   // Type code to behaviour; unlisted codes behave as the plain clamped kind
   function automatic ctype_attr_t decode_ctype(input logic [2:0] code);
      ctype_attr_t a;
      case (code)
         3'd2, 3'd5: a = '{pass_preset: 1'b1, keep_on_loss: 1'b0};
         3'd3:       a = '{pass_preset: 1'b0, keep_on_loss: 1'b1};
         3'd4, 3'd6: a = '{pass_preset: 1'b1, keep_on_loss: 1'b1};
         default:    a = '{pass_preset: 1'b0, keep_on_loss: 1'b0};
      endcase
      return a;
   endfunction

endpackage

// File: rtl/scan_edge.sv
module scan_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   generate
      if (RISING) begin : g_lead
         assign pulse = sig & ~prev_q;
      end else begin : g_trail
         assign pulse = ~sig & prev_q;
      end
   endgenerate

   // R2
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/cnt_type_dec.sv
module cnt_type_dec
   import scan_cnt_pkg::*;
#(
   parameter int unsigned CODE_W = 3
) (
   input  logic [CODE_W-1:0] code,
   output logic              pass_preset,
   output logic              keep_on_loss
);
   ctype_attr_t attr;

   generate
      if (CODE_W == 3) begin : g_native
         assign attr = decode_ctype(code);
      end else begin : g_resize
         assign attr = decode_ctype(3'(code));
      end
   endgenerate

   assign pass_preset  = attr.pass_preset;
   assign keep_on_loss = attr.keep_on_loss;
endmodule

// File: rtl/cnt_acc.sv
module cnt_acc #(
   parameter int unsigned W       = 20,
   parameter int unsigned MAX_VAL = 999999
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         down,
   input  logic         clr,
   input  logic         restore,
   input  logic [W-1:0] saved,
   input  logic [W-1:0] preset,
   input  logic         pass_preset,
   input  logic         keep_on_loss,
   output logic [W-1:0] acc
);
   localparam logic [W-1:0] TOP = W'(MAX_VAL);

   logic [W-1:0] acc_q, acc_d, reload;

   assign reload = keep_on_loss ? ((saved > TOP) ? TOP : saved) : '0;

   always_comb begin
      acc_d = acc_q;
      if (clr) begin
         acc_d = '0;
      end else if (restore) begin
         acc_d = reload;
      end else if (step) begin
         if (down) begin
            if (acc_q != '0) acc_d = acc_q - 1'b1;
         end else if (acc_q != TOP && (pass_preset || acc_q < preset)) begin
            acc_d = acc_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   assign acc = acc_q;

   // R4
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));
   // R7
   ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc <= TOP);
   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !down && !pass_preset && acc >= preset && !clr && !restore) |=> $stable(acc));
   // R8
   floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && down && acc == '0 && !clr && !restore) |=> (acc == '0));
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr && !restore) |=> $stable(acc));
   // R3
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !restore) |=>
         (acc == $past(acc) || acc == $past(acc) + 1'b1 || acc + 1'b1 == $past(acc)));
endmodule

// File: rtl/preset_event_counter.sv
module preset_event_counter #(
   parameter int unsigned W       = 20,
   parameter int unsigned CODE_W  = 3,
   parameter int unsigned MAX_VAL = 999999,
   parameter bit          RISING  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_in,
   input  logic              dir_dn,
   input  logic              clr,
   input  logic [CODE_W-1:0] ctype,
   input  logic [W-1:0]      preset,
   input  logic              restore,
   input  logic [W-1:0]      saved_val,
   output logic [W-1:0]      acc,
   output logic              hit
);
   localparam longint unsigned SPAN = longint'(1) << W;

   generate
      if (longint'(MAX_VAL) >= SPAN) begin : g_bad_max
         $error("MAX_VAL does not fit in W bits");
      end
      if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code
         $error("CODE_W must be 1 to 3");
      end
   endgenerate

   logic step, pass_preset, keep_on_loss;

   scan_edge #(.RISING(RISING)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig(count_in), .pulse(step));

   cnt_type_dec #(.CODE_W(CODE_W)) u_dec (
      .code(ctype), .pass_preset(pass_preset), .keep_on_loss(keep_on_loss));

   cnt_acc #(.W(W), .MAX_VAL(MAX_VAL)) u_acc (
      .clk(clk), .rst_n(rst_n), .step(step), .down(dir_dn), .clr(clr),
      .restore(restore), .saved(saved_val), .preset(preset),
      .pass_preset(pass_preset), .keep_on_loss(keep_on_loss), .acc(acc));

   assign hit = (acc >= preset);

   // R9
   restore_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore && !clr && !keep_on_loss) |=> (acc == '0));
endmodule

// File: tb/preset_event_counter_tb.sv
`timescale 1ns/1ps
module preset_event_counter_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic count_in = 1'b0, dir_dn = 1'b0, clr = 1'b0, restore = 1'b0;
   logic [2:0]  ctype = 3'd1;
   logic [19:0] preset = 20'd3, saved_val = '0;
   logic [19:0] acc;
   logic        hit;
   int total = 0, bad = 0;
   int exp_acc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   preset_event_counter u_dut (
      .clk(clk), .rst_n(rst_n), .count_in(count_in), .dir_dn(dir_dn), .clr(clr),
      .ctype(ctype), .preset(preset), .restore(restore), .saved_val(saved_val),
      .acc(acc), .hit(hit));

   function automatic bit can_pass(input logic [2:0] t);
      return (t == 3'd2 || t == 3'd4 || t == 3'd5 || t == 3'd6);
   endfunction
   function automatic bit retains(input logic [2:0] t);
      return (t == 3'd3 || t == 3'd4 || t == 3'd6);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_both(input string req);
      chk(req, int'(acc), exp_acc);
      chk({req, "/R5 hit"}, int'(hit), (exp_acc >= int'(preset)) ? 1 : 0);
   endtask

   task automatic pulse(input bit dn, input string req);
      @(negedge clk); count_in = 1'b1; dir_dn = dn;
      @(negedge clk); count_in = 1'b0;
      if (dn) begin
         if (exp_acc > 0) exp_acc--;
      end else if (exp_acc < 999999 && (can_pass(ctype) || exp_acc < int'(preset))) begin
         exp_acc++;
      end
      chk_both(req);
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      exp_acc = 0;
      chk_both("R4 clear");
   endtask

   task automatic do_restore(input int v);
      @(negedge clk); restore = 1'b1; saved_val = 20'(v);
      @(negedge clk); restore = 1'b0;
      exp_acc = retains(ctype) ? ((v > 999999) ? 999999 : v) : 0;
      chk_both("R9 restore");
   endtask

   initial begin
      #200000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_both("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_both("R1 after release");

      for (int t = 0; t < 8; t++) begin
         ctype = 3'(t); preset = 20'd3;
         do_clear();
         for (int k = 0; k < 6; k++)
            pulse(1'b0, can_pass(ctype) ? "R7 pass preset" : "R6 stop at preset");
         for (int k = 0; k < 8; k++) pulse(1'b1, "R3/R8 count down");
         // level held high counts once (R2)
         @(negedge clk); count_in = 1'b1; dir_dn = 1'b0;
         repeat (5) @(negedge clk);
         count_in = 1'b0;
         exp_acc = 1;
         chk_both("R2 held level");
         do_restore(12345);
         do_restore(20'hFFFFF);
      end

      // clear and count edge in the same scan (R4)
      ctype = 3'd2; preset = 20'd100;
      do_clear();
      pulse(1'b0, "R2 up"); pulse(1'b0, "R2 up");
      @(negedge clk); count_in = 1'b1; clr = 1'b1;
      @(negedge clk); count_in = 1'b0; clr = 1'b0;
      exp_acc = 0; chk_both("R4 clear beats edge");

      // restore and count edge in the same scan (R9)
      ctype = 3'd4;
      @(negedge clk); count_in = 1'b1; restore = 1'b1; saved_val = 20'd50;
      @(negedge clk); count_in = 1'b0; restore = 1'b0;
      exp_acc = 50; chk_both("R9 restore beats edge");

      // ceiling (R7)
      do_restore(999998);
      pulse(1'b0, "R7 reach ceiling");
      pulse(1'b0, "R7 hold ceiling");
      chk("R7 ceiling value", int'(acc), 999999);

      // preset of zero (R5)
      ctype = 3'd1; preset = 20'd0;
      do_clear();
      chk("R5 zero preset hit", int'(hit), 1);
      pulse(1'b0, "R6 zero preset blocks up");

      // preset lowered below value on clamped type (R6)
      ctype = 3'd3; preset = 20'd10;
      do_restore(8);
      preset = 20'd5;
      pulse(1'b0, "R6 above preset holds");
      pulse(1'b1, "R6 down still allowed");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule